// File: doc/BRIEF.md
# Calibrated Signed Hex Axis Readout

This block turns one 16-bit two's-complement axis sample into the values a seven-segment display needs. The display shows the sample in sign-and-magnitude hexadecimal. Only the upper 13 bits of the sample are used. The block produces one sign digit and three magnitude hex digits. It also drives the segment pattern of the sign digit directly, so a negative value lights a minus bar and a zero or positive value leaves the sign digit dark.

A calibration control sets a new zero point. When the control rises, the block stores the negated current reading as an offset. While the control stays high, that offset is added to every later reading, so the orientation captured at calibration reads as zero. The corrected sum is clamped to the 13-bit signed range rather than wrapping. When the control is low, the raw reading is shown.

The outputs are registered and change only on a sample strobe. One instance serves one axis. Digit scanning and the data source sit outside this block.

Top module: `axis_hex_readout`

## Requirements
- R1: While reset is active, and after it until the first strobe, `neg_o` is 0, `digits_o` is 0 and `sign_seg_o` is all zero.
- R2: The displayed reading is sample bits [15:3], taken as a 13-bit signed value. Bits [2:0] have no effect on any output.
- R3: `sign_seg_o` uses bit order a..g in bits [0..6], active high. A negative displayed value gives 7'b1000000, which lights only the middle segment g. A zero or positive value gives 7'b0000000. `neg_o` is 1 exactly for a negative value.
- R4: For a zero or positive displayed value v, `digits_o` equals v, with the most significant digit in bits [11:8] and the least significant in bits [3:0]. A reading of 1 gives sign blank and digits 0,0,1.
- R5: For a negative displayed value v, `digits_o` equals -v. A reading of -1 (all 13 bits set) gives minus and digits 0,0,1.
- R6: The most negative reading, -4096, gives minus with magnitude 0x1000 truncated to three digits, so `digits_o` is 0x000.
- R7: While `cal_i` is low, no offset is applied and the raw reading is shown.
- R8: On the cycle where `cal_i` rises, the offset becomes the negation of the current reading. If a strobe comes in that cycle, it shows zero. The offset is captured whether or not a strobe is present.
- R9: While `cal_i` stays high, the captured offset is held. Each strobed reading r shows r minus the captured value. A later rise recaptures the offset.
- R10: The offset-corrected value saturates at +4095 and -4096.
- R11: Outputs change only in the cycle after `valid_i` is high at a clock edge. Otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | 16 | Two's-complement axis sample |
| cal_i | input | 1 | Calibration control; rising edge captures a new zero |
| neg_o | output | 1 | Displayed value is negative |
| sign_seg_o | output | 7 | Sign-digit segments a..g, active high |
| digits_o | output | 12 | Three magnitude hex digits, most significant in [11:8] |

## Verification
Every result is due one clock after the edge that sees `valid_i` high. The bench drives inputs just after a falling edge and checks just after the next falling edge, so exactly one rising edge lies between stimulus and check. The offset capture on a rise of `cal_i` acts in that same edge. A calibration strobe is therefore checked for zero in the following cycle, and the readings strobed after it are checked one cycle each. The hold check drops the strobe for a cycle, changes the sample and the low bits, and then confirms at the next falling edge that the outputs kept their previous values.

// File: rtl/axis_hex_pkg.sv
package axis_hex_pkg;
  localparam int unsigned SEG_W = 7;
  // segment order a..g in bits 0..6, active high
  localparam logic [SEG_W-1:0] SEG_MINUS = 7'b100_0000;
  localparam logic [SEG_W-1:0] SEG_BLANK = 7'b000_0000;
endpackage

// File: rtl/axis_cal_offset.sv
module axis_cal_offset #(
  parameter int unsigned DISP_W = 13
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cal_i,
  input  logic [DISP_W-1:0]        value_i,
  output logic signed [DISP_W:0]   offset_o
);
  logic                   cal_q;
  logic signed [DISP_W:0] off_q;
  logic signed [DISP_W:0] val_ext;
  logic signed [DISP_W:0] neg_val;
  logic                   cal_rise;

  assign cal_rise = cal_i & ~cal_q;
  assign val_ext  = {value_i[DISP_W-1], value_i};
  assign neg_val  = -val_ext;

  // the capture cycle already uses the fresh offset so it reads zero
  always_comb begin
    if (!cal_i)        offset_o = '0;
    else if (cal_rise) offset_o = neg_val;
    else               offset_o = off_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q <= 1'b0;
      off_q <= '0;
    end else begin
      cal_q <= cal_i;
      if (cal_rise)   off_q <= neg_val;
      else if (!cal_i) off_q <= '0;
    end
  end
endmodule

// File: rtl/axis_sat_add.sv
module axis_sat_add #(
  parameter int unsigned DISP_W = 13
) (
  input  logic [DISP_W-1:0]      value_i,
  input  logic signed [DISP_W:0] offset_i,
  output logic [DISP_W-1:0]      sum_o
);
  localparam int unsigned WIDE_W = DISP_W + 2;
  localparam logic signed [WIDE_W-1:0] SAT_MAX = {3'b000, {(DISP_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] SAT_MIN = {3'b111, {(DISP_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] a_ext;
  logic signed [WIDE_W-1:0] b_ext;
  logic signed [WIDE_W-1:0] wide;

  assign a_ext = {{2{value_i[DISP_W-1]}}, value_i};
  assign b_ext = {offset_i[DISP_W], offset_i};
  assign wide  = a_ext + b_ext;

  always_comb begin
    if (wide > SAT_MAX)      sum_o = SAT_MAX[DISP_W-1:0];
    else if (wide < SAT_MIN) sum_o = SAT_MIN[DISP_W-1:0];
    else                     sum_o = wide[DISP_W-1:0];
  end
endmodule

// File: rtl/axis_sign_mag.sv
module axis_sign_mag #(
  parameter int unsigned DISP_W = 13,
  parameter int unsigned DIG_W  = 4,
  parameter int unsigned N_DIG  = 3
) (
  input  logic [DISP_W-1:0]        value_i,
  output logic                     neg_o,
  output logic [N_DIG*DIG_W-1:0]   digits_o
);
  logic [DISP_W-1:0] mag;

  assign neg_o = value_i[DISP_W-1];
  // most negative value wraps to 1000...0, upper digit dropped below
  assign mag   = neg_o ? (~value_i + 1'b1) : value_i;

  for (genvar d = 0; d < N_DIG; d++) begin : g_dig
    assign digits_o[d*DIG_W +: DIG_W] = mag[d*DIG_W +: DIG_W];
  end
endmodule

// File: rtl/axis_hex_readout.sv
module axis_hex_readout #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DISP_W   = 13,
  parameter int unsigned DIG_W    = 4,
  parameter int unsigned N_DIG    = (DISP_W - 1) / DIG_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic                    cal_i,
  output logic                    neg_o,
  output logic [6:0]              sign_seg_o,
  output logic [N_DIG*DIG_W-1:0]  digits_o
);
  import axis_hex_pkg::*;

  localparam int unsigned OUT_W = N_DIG * DIG_W;

  logic [DISP_W-1:0]      disp_val;
  logic signed [DISP_W:0] offset;
  logic [DISP_W-1:0]      corrected;
  logic                   neg_d;
  logic [OUT_W-1:0]       dig_d;

  assign disp_val = sample_i[SAMPLE_W-1 -: DISP_W];

  axis_cal_offset #(.DISP_W(DISP_W)) i_cal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cal_i    (cal_i),
    .value_i  (disp_val),
    .offset_o (offset)
  );

  axis_sat_add #(.DISP_W(DISP_W)) i_add (
    .value_i  (disp_val),
    .offset_i (offset),
    .sum_o    (corrected)
  );

  axis_sign_mag #(.DISP_W(DISP_W), .DIG_W(DIG_W), .N_DIG(N_DIG)) i_fmt (
    .value_i  (corrected),
    .neg_o    (neg_d),
    .digits_o (dig_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_o      <= 1'b0;
      sign_seg_o <= SEG_BLANK;
      digits_o   <= '0;
    end else if (valid_i) begin
      neg_o      <= neg_d;
      sign_seg_o <= neg_d ? SEG_MINUS : SEG_BLANK;
      digits_o   <= dig_d;
    end
  end
endmodule

// File: rtl/axis_hex_readout_chk.sv
module axis_hex_readout_chk #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned OUT_W    = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic                cal_i,
  input logic                neg_o,
  input logic [6:0]          sign_seg_o,
  input logic [OUT_W-1:0]    digits_o
);
  // R11: outputs hold without a strobe
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(digits_o) && $stable(neg_o) && $stable(sign_seg_o)));

  // R3: sign digit lights at most the middle segment
  p_sign_seg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sign_seg_o) && (sign_seg_o[5:0] == 6'd0) && (sign_seg_o[6] == neg_o));

  // R7: raw negative sample with no calibration shows minus
  p_raw_neg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cal_i && sample_i[SAMPLE_W-1]) |=> neg_o);

  // R7: raw non-negative sample shows blank sign
  p_raw_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cal_i && !sample_i[SAMPLE_W-1]) |=> !neg_o);

  // R8: strobe on calibration rise reads zero
  p_cal_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cal_i && !$past(cal_i)) |=> (digits_o == '0 && !neg_o));
endmodule

bind axis_hex_readout axis_hex_readout_chk #(
  .SAMPLE_W(SAMPLE_W),
  .OUT_W   (N_DIG*DIG_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .sample_i   (sample_i),
  .cal_i      (cal_i),
  .neg_o      (neg_o),
  .sign_seg_o (sign_seg_o),
  .digits_o   (digits_o)
);

// File: tb/test_axis_hex_readout.sv
module test_axis_hex_readout;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic        cal_i = 1'b0;
  logic        neg_o;
  logic [6:0]  sign_seg_o;
  logic [11:0] digits_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  axis_hex_readout i_axis_hex_readout (
    .clk_i, .rst_ni, .valid_i, .sample_i, .cal_i,
    .neg_o, .sign_seg_o, .digits_o
  );

  function automatic logic [15:0] mk(int v);
    logic [12:0] t;
    t = 13'(v);
    return {t, 3'($urandom)};
  endfunction

  task automatic check(string req, bit en, int cap, int v);
    int s; bit n; int m; logic [6:0] seg;
    s = en ? v - cap : v;
    if (s > 4095) s = 4095;
    if (s < -4096) s = -4096;
    n = s < 0;
    m = (n ? -s : s) & 12'hFFF;
    seg = n ? 7'b100_0000 : 7'b0;
    n_vec++;
    if (neg_o !== n || digits_o !== 12'(m) || sign_seg_o !== seg) begin
      n_bad++;
      $display("FAIL %s: v=%0d cap=%0d got neg=%b dig=%h seg=%b exp neg=%b dig=%h seg=%b",
               req, v, cap, neg_o, digits_o, sign_seg_o, n, 12'(m), seg);
    end
  endtask

  // drive after negedge, one rising edge, check after next negedge
  task automatic step(int v, bit c, bit vld);
    sample_i = mk(v);
    cal_i    = c;
    valid_i  = vld;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    int caps[8];
    caps = '{0, 1, -1, 4095, -4096, 100, -2000, 1234};
    sample_i = 16'h8008;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", 1'b0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 1'b0, 0, 0);

    // R4 R5: named corner readings
    step(1, 1'b0, 1'b1);     check("R4", 1'b0, 0, 1);
    step(-1, 1'b0, 1'b1);    check("R5", 1'b0, 0, -1);
    step(-4096, 1'b0, 1'b1); check("R6", 1'b0, 0, -4096);
    step(4095, 1'b0, 1'b1);  check("R4", 1'b0, 0, 4095);

    // R2 R3 R7: exhaustive raw sweep with random low bits
    for (int v = -4096; v < 4096; v++) begin
      step(v, 1'b0, 1'b1);
      check((v < 0) ? "R3/R5/R7" : "R2/R4/R7", 1'b0, 0, v);
    end

    // R11: no strobe, sample changes, outputs hold at last value (4095)
    step(-77, 1'b0, 1'b0); check("R11", 1'b0, 0, 4095);
    step(12, 1'b0, 1'b0);  check("R11", 1'b0, 0, 4095);

    // R8 R9 R10: calibration captures with a strided sweep
    for (int k = 0; k < 8; k++) begin
      step(0, 1'b0, 1'b1);
      step(caps[k], 1'b1, 1'b1);
      check("R8", 1'b1, caps[k], caps[k]);
      for (int v = -4096; v < 4096; v += 37) begin
        step(v, 1'b1, 1'b1);
        check("R9/R10", 1'b1, caps[k], v);
      end
      step(4095, 1'b1, 1'b1);  check("R10", 1'b1, caps[k], 4095);
      step(-4096, 1'b1, 1'b1); check("R10", 1'b1, caps[k], -4096);
    end

    // R8: capture on rise without a strobe still takes effect
    step(0, 1'b0, 1'b1);
    step(500, 1'b1, 1'b0);
    step(600, 1'b1, 1'b1); check("R8", 1'b1, 500, 600);
    // R9: held capture, sample moves back to captured point
    step(500, 1'b1, 1'b1); check("R9", 1'b1, 500, 500);

    // R7: dropping calibration clears the offset
    step(600, 1'b0, 1'b1); check("R7", 1'b0, 0, 600);
    // R9: a new rise recaptures
    step(-300, 1'b1, 1'b1); check("R9", 1'b1, -300, -300);
    step(-290, 1'b1, 1'b1); check("R9", 1'b1, -300, -290);

    done = 1'b1;
    finish_run();
  end
endmodule